// File: doc/BRIEF.md
# UART Automatic Flow-Control Controller

This block holds the control register and the hardware handshake logic of a small UART. Software reaches an 8-bit control register and a one-bit modem-control register over a simple register bus. The control register enables the receiver and the transmitter separately and configures automatic handshaking in both directions. The serial shifters, the baud generator and the FIFO storage sit outside this block.

When automatic RTS is on, the RTS pin is derived from the free space in the 8-entry receive FIFO. The threshold is selected by a 2-bit code, and the output polarity can be inverted. When automatic RTS is off, the pin follows a software bit. The CTS pin passes through a two-flop synchronizer. When automatic CTS is on, an inactive CTS withholds permission to start the next transmit character. A character that is already being shifted out is never cut short.

Top module: `uart_flowctl`

## Requirements
- R1: After reset the control register reads 0x03 and the modem-control register reads 0x00. `rx_enable` and `tx_enable` are high and `rts_pin` is low.
- R2: The register index is `reg_addr` shifted right by 2. Index 0 is the control register and index 1 is the modem-control register, of which only bit 0 is kept and the other bits read 0. Any other index reads 0 and ignores writes. Reads are combinational.
- R3: Control bit 0 drives `rx_enable` and control bit 1 drives `tx_enable`.
- R4: With control bit 2 clear, `rts_pin` equals modem-control bit 0 one clock after it is written. Control bit 6 has no effect in this mode.
- R5: With control bit 2 set, `rts_pin` is registered and updates one clock after `rx_level` or the control register changes. Let free = 8 − `rx_level`. The RTS output is active (high) while free exceeds the threshold and inactive (low) otherwise. Control bits 5:4 encode the threshold: 00 = 3, 01 = 2, 10 = 1, 11 = 4.
- R6: Control bit 6 inverts the automatic RTS output, so that active is driven low.
- R7: `cts_pin` passes through two flops. A change on the pin reaches `tx_start_permit` after the second rising edge, and not after the first.
- R8: With control bit 3 set, `tx_start_permit` is low while CTS is inactive (pin low when bit 7 is clear). With bit 3 clear, CTS has no effect.
- R9: Control bit 7 inverts the CTS input, so that CTS is active when the pin is low.
- R10: `tx_start_permit` is high only while `tx_enable` and `tx_idle` are both high. A busy transmitter therefore keeps its current character regardless of CTS.
- R11: With control bits 1:0 both cleared, `rx_enable` and `tx_enable` are low and `tx_start_permit` stays low for any CTS or idle input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address; register index is addr >> 2 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| rx_level | input | 4 | Receive FIFO occupancy, 0 to 8 |
| tx_idle | input | 1 | Transmitter has no character in flight |
| cts_pin | input | 1 | Clear-to-send pin, asynchronous |
| rts_pin | output | 1 | Request-to-send pin |
| rx_enable | output | 1 | Receiver enable |
| tx_enable | output | 1 | Transmitter enable |
| tx_start_permit | output | 1 | A new transmit character may start |

## Verification
The hardest case to reach from the ports is the exact edge of each RTS threshold under every code. Each case needs a control write followed by a FIFO level that leaves free space either one above the threshold or exactly at it. A table walks these pairs for all four codes, with and without inversion, including an empty and a full FIFO. The CTS path is probed one edge after a pin change and again after the second edge, which exposes a missing or extra synchronizer stage.

// File: rtl/uart_flowctl.sv
module uart_flowctl #(
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level,
  input  logic              tx_idle,
  input  logic              cts_pin,
  output logic              rts_pin,
  output logic              rx_enable,
  output logic              tx_enable,
  output logic              tx_start_permit
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(8'h03);

  logic [DATA_W-1:0] ctrl_q;
  logic              mcr_q;
  logic              cts_s1, cts_s2;
  logic              rts_q;
  logic [IDX_W-1:0]  idx;
  logic [LVL_W:0]    free_slots;
  logic [2:0]        thr;
  logic              auto_active, rts_next, cts_active;
  wire               unused_addr = &{1'b0, reg_addr[1:0]};

  assign idx = reg_addr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      mcr_q  <= 1'b0;
    end else if (reg_we) begin
      if (idx == IDX_W'(0)) ctrl_q <= reg_wdata;
      if (idx == IDX_W'(1)) mcr_q  <= reg_wdata[0];
    end

  always_comb
    case (idx)
      IDX_W'(0): reg_rdata = ctrl_q;
      IDX_W'(1): reg_rdata = {{(DATA_W-1){1'b0}}, mcr_q};
      default:   reg_rdata = '0;
    endcase

  always_comb
    case (ctrl_q[5:4])
      2'b00: thr = 3'd3;
      2'b01: thr = 3'd2;
      2'b10: thr = 3'd1;
      default: thr = 3'd4;
    endcase

  assign free_slots  = (LVL_W+1)'(FIFO_DEPTH) - {1'b0, rx_level};
  assign auto_active = free_slots > (LVL_W+1)'(thr);
  assign rts_next    = ctrl_q[2] ? (auto_active ^ ctrl_q[6]) : mcr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rts_q  <= 1'b0;
      cts_s1 <= 1'b0;
      cts_s2 <= 1'b0;
    end else begin
      rts_q  <= rts_next;
      cts_s1 <= cts_pin;
      cts_s2 <= cts_s1;
    end

  assign cts_active      = cts_s2 ^ ctrl_q[7];
  assign rts_pin         = rts_q;
  assign rx_enable       = ctrl_q[0];
  assign tx_enable       = ctrl_q[1];
  assign tx_start_permit = ctrl_q[1] & tx_idle & (~ctrl_q[3] | cts_active);

  // R1
  reset_value_chk: assert property (@(posedge clk) $rose(rst_n) |-> ctrl_q == CTRL_RST && !rts_q);

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_we) && $past(idx) == IDX_W'(0) |-> ctrl_q == $past(reg_wdata));

  // R4
  rts_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(ctrl_q[2]) |-> rts_pin == $past(mcr_q));

  // R5
  rts_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ctrl_q[2]) && $past(ctrl_q[5:4]) == 2'b10 &&
    $past(rx_level) == LVL_W'(FIFO_DEPTH) |-> rts_pin == $past(ctrl_q[6]));

  // R7
  cts_sync1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cts_s1 == $past(cts_pin));

  // R7
  cts_sync2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cts_s2 == $past(cts_s1));
endmodule

// File: tb/uart_flowctl_tb.sv
module uart_flowctl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_we = 0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] rx_level = '0;
  logic       tx_idle = 1;
  logic       cts_pin = 0;
  logic       rts_pin, rx_enable, tx_enable, tx_start_permit;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flowctl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_level(rx_level),
    .tx_idle(tx_idle), .cts_pin(cts_pin), .rts_pin(rts_pin),
    .rx_enable(rx_enable), .tx_enable(tx_enable), .tx_start_permit(tx_start_permit)
  );

  // {ctrl, rx_level, expected rts}
  localparam logic [12:0] VEC [0:10] = '{
    {8'h07, 4'd4, 1'b1}, {8'h07, 4'd5, 1'b0},
    {8'h17, 4'd5, 1'b1}, {8'h17, 4'd6, 1'b0},
    {8'h27, 4'd6, 1'b1}, {8'h27, 4'd7, 1'b0},
    {8'h37, 4'd3, 1'b1}, {8'h37, 4'd4, 1'b0},
    {8'h47, 4'd4, 1'b0}, {8'h47, 4'd5, 1'b1},
    {8'h27, 4'd8, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_addr = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 2); rst_n = 1;
    @(negedge clk);
    reg_addr = 4'h0; #1; chk("R1 ctrl", reg_rdata, 8'h03);
    reg_addr = 4'h4; #1; chk("R1 mcr", reg_rdata, 8'h00);
    chk("R1 enables", {rx_enable, tx_enable}, 8'h3);
    chk("R1 rts", rts_pin, 0);

    foreach (VEC[i]) begin
      wr(4'h0, VEC[i][12:5]);
      rx_level = VEC[i][4:1];
      step();
      chk($sformatf("R5/R6 vec%0d", i), rts_pin, VEC[i][0]);
    end
    rx_level = 0; wr(4'h0, 8'h37); step(); chk("R5 empty", rts_pin, 1);

    wr(4'h0, 8'h43); wr(4'h4, 8'hFF); step();
    chk("R4 soft high", rts_pin, 1);
    reg_addr = 4'h4; #1; chk("R2 mcr bits", reg_rdata, 8'h01);
    wr(4'h4, 8'h00); step(); chk("R4 soft low", rts_pin, 0);
    wr(4'h8, 8'h5A);
    reg_addr = 4'h8; #1; chk("R2 unmapped", reg_rdata, 8'h00);
    reg_addr = 4'h1; #1; chk("R2 index shift", reg_rdata, 8'h43);
    chk("R3 enables", {rx_enable, tx_enable}, 8'h3);
    wr(4'h0, 8'h01); chk("R3 rx only", {rx_enable, tx_enable}, 8'h2);

    tx_idle = 1; cts_pin = 0;
    wr(4'h0, 8'h0B); step(); step();
    chk("R8 cts low blocks", tx_start_permit, 0);
    @(negedge clk); cts_pin = 1; step();
    chk("R7 one edge", tx_start_permit, 0);
    step(); chk("R7 two edges", tx_start_permit, 1);
    @(negedge clk); tx_idle = 0; #1;
    chk("R10 busy", tx_start_permit, 0);
    tx_idle = 1;
    wr(4'h0, 8'h8B); step(); chk("R9 inverted high", tx_start_permit, 0);
    @(negedge clk); cts_pin = 0; step(); step();
    chk("R9 inverted low", tx_start_permit, 1);
    wr(4'h0, 8'h03); cts_pin = 0; step(); step();
    chk("R8 cts ignored", tx_start_permit, 1);
    wr(4'h0, 8'h00); cts_pin = 1; step(); step();
    chk("R11 permit", tx_start_permit, 0);
    chk("R11 enables", {rx_enable, tx_enable}, 8'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule